// File: doc/BRIEF.md
# Fully Associative Tag Store with Rotating-Pointer Replacement

This block is the tag side of a 64-entry fully associative cache for 32-bit byte addresses and 32-byte blocks. There is no index field, so any block may occupy any entry. A lookup compares the tag part of the address against all valid entries in parallel. In the same cycle it returns a hit flag and the number of the matching entry, which can address a separate data array.

A fill is modelled as an allocate strobe that carries the address of the new block. While some entries are still empty, the new tag goes into the lowest-numbered empty entry. Once all entries are valid, the new tag goes into the entry named by a single rotating replacement pointer. This gives a cheap approximation of least-recently-used.

The pointer advances by one only when the entry it names is accessed, either by a lookup hit or by being refilled. It stays where it is when any other entry is hit. Allocating a tag that is already present changes nothing.

Top module: `assoc_tag_store`

## Requirements
- R1: After reset every entry is invalid, `hit` is 0, `hit_idx` is 0, `repl_ptr` is 0 and `fill_idx` is 0.
- R2: The tag is address bits 31..5. Bits 4..0 are the byte select and have no effect on whether a lookup hits or on which entry it reports.
- R3: During a cycle with `lkp_valid` high, `hit` is 1 exactly when a valid entry holds the lookup tag, and `hit_idx` is that entry in the same cycle. At most one entry ever matches. When `hit` is 0, `hit_idx` is 0.
- R4: While at least one entry is invalid, `fill_idx` names the lowest-numbered invalid entry. An allocation writes its tag there, marks the entry valid, and does not move the pointer.
- R5: While all entries are valid, `fill_idx` equals `repl_ptr`. An allocation replaces that entry's tag, and the pointer advances by one at the next clock edge.
- R6: A lookup hit on the entry named by `repl_ptr` advances the pointer by one at the next edge. A hit on any other entry, a miss, or an idle cycle leaves it unchanged.
- R7: The pointer advances from entry 63 to entry 0.
- R8: An allocation whose tag already sits in a valid entry leaves all entries and the pointer unchanged.
- R9: When a lookup and an allocation occur in the same cycle, the lookup sees the contents from before the clock edge. The allocation's duplicate check also uses those contents. The pointer moves by at most one step even if both events touch the pointed entry.
- R10: Up to 64 blocks coexist regardless of their address bits, including blocks whose low tag bits are all identical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_addr | input | 32 | Byte address to look up |
| alloc_valid | input | 1 | Allocate (fill) request this cycle |
| alloc_addr | input | 32 | Byte address of the block to install |
| hit | output | 1 | Lookup matched a valid entry |
| hit_idx | output | 6 | Matching entry number, 0 on miss |
| fill_idx | output | 6 | Entry an allocation would use this cycle |
| repl_ptr | output | 6 | Current replacement pointer |

## Verification
A lookup and an allocation can fall in the same cycle. The case of interest is a lookup that hits the pointed entry while a full-cache allocation evicts that same entry. The bench provokes this on purpose, and a random phase draws both from a small tag pool so that the overlap recurs. It judges the outcome against a behavioural model of the pre-edge state: the lookup must still report the old tag at the old pointer, the pointer must move exactly one step, and in the next cycle the evicted tag must miss while the new tag hits.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

  // Successor of a slot number in a ring of n slots.
  function automatic int unsigned step_slot(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // True when the pointer must move: pointed entry hit, or refilled when full.
  function automatic logic ptr_touch(input logic hit_on_ptr, input logic fill_when_full);
    return hit_on_ptr | fill_when_full;
  endfunction

endpackage

// File: rtl/assoc_prio_pick.sv
module assoc_prio_pick #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Lowest set bit wins.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/assoc_tag_array.sv
module assoc_tag_array #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 27,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   lkp_tag,
  input  logic [TAG_W-1:0]   new_tag,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] dup_vec,
  output logic [ENTRIES-1:0] valid_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             v_q;
    logic [TAG_W-1:0] t_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        v_q <= 1'b1;
        t_q <= new_tag;
      end
    end

    assign valid_vec[g] = v_q;
    assign match_vec[g] = v_q && (t_q == lkp_tag);
    assign dup_vec[g]   = v_q && (t_q == new_tag);
  end
endmodule

// File: rtl/assoc_repl_ptr.sv
module assoc_repl_ptr #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= IDX_W'(assoc_pkg::step_slot(int'(ptr), ENTRIES));
    end
  end
endmodule

// File: rtl/assoc_tag_store.sv
module assoc_tag_store #(
  parameter int ADDR_W  = 32,
  parameter int OFFS_W  = 5,
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  input  logic              alloc_valid,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [IDX_W-1:0]  repl_ptr
);
  localparam int TAG_W = ADDR_W - OFFS_W;

  logic [TAG_W-1:0]   lkp_tag, new_tag;
  logic [ENTRIES-1:0] match_vec, dup_vec, valid_vec;
  logic               any_match, any_free, full, alloc_dup, wr_en;
  logic [IDX_W-1:0]   match_idx, free_idx;
  logic               hit_on_ptr, fill_on_ptr, ptr_adv;

  assign lkp_tag = lkp_addr[ADDR_W-1:OFFS_W];
  assign new_tag = alloc_addr[ADDR_W-1:OFFS_W];

  assoc_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_tag   (lkp_tag),
    .new_tag   (new_tag),
    .wr_en     (wr_en),
    .wr_idx    (fill_idx),
    .match_vec (match_vec),
    .dup_vec   (dup_vec),
    .valid_vec (valid_vec)
  );

  assoc_prio_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_enc (
    .req (match_vec),
    .any (any_match),
    .idx (match_idx)
  );

  assoc_prio_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_pick (
    .req (~valid_vec),
    .any (any_free),
    .idx (free_idx)
  );

  assoc_repl_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (ptr_adv),
    .ptr     (repl_ptr)
  );

  assign full        = !any_free;
  assign alloc_dup   = |dup_vec;
  assign wr_en       = alloc_valid && !alloc_dup;
  assign fill_idx    = any_free ? free_idx : repl_ptr;

  assign hit         = lkp_valid && any_match;
  assign hit_idx     = hit ? match_idx : '0;

  assign hit_on_ptr  = hit && (match_idx == repl_ptr);
  assign fill_on_ptr = wr_en && full;
  assign ptr_adv     = assoc_pkg::ptr_touch(hit_on_ptr, fill_on_ptr);
endmodule

// File: rtl/assoc_tag_store_chk.sv
module assoc_tag_store_chk #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hit,
  input logic [IDX_W-1:0]   hit_idx,
  input logic [IDX_W-1:0]   fill_idx,
  input logic [IDX_W-1:0]   repl_ptr,
  input logic               full,
  input logic               alloc_valid,
  input logic               alloc_dup,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] valid_vec
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  // R3
  match_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R3
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> hit_idx == '0);

  // R4
  free_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !valid_vec[fill_idx]);

  // R5
  full_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> fill_idx == repl_ptr);

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && hit_idx == repl_ptr) && !(alloc_valid && !alloc_dup && full)
    |=> $stable(repl_ptr));

  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_idx == LAST && repl_ptr == LAST) |=> repl_ptr == '0);

  // R8
  dup_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_dup) |=> $stable(valid_vec));

  // R9
  ptr_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (repl_ptr == $past(repl_ptr)) ||
              (repl_ptr == IDX_W'(assoc_pkg::step_slot(int'($past(repl_ptr)), ENTRIES))));
endmodule

bind assoc_tag_store assoc_tag_store_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hit         (hit),
  .hit_idx     (hit_idx),
  .fill_idx    (fill_idx),
  .repl_ptr    (repl_ptr),
  .full        (full),
  .alloc_valid (alloc_valid),
  .alloc_dup   (alloc_dup),
  .match_vec   (match_vec),
  .valid_vec   (valid_vec)
);

// File: tb/assoc_tag_store_tb.sv
module assoc_tag_store_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 1'b0, alloc_valid = 1'b0;
  logic [31:0] lkp_addr = '0, alloc_addr = '0;
  logic        hit;
  logic [5:0]  hit_idx, fill_idx, repl_ptr;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // reference model state
  bit          mv[64];
  int unsigned mt[64];
  int unsigned mptr = 0;

  always #2 clk = ~clk;

  assoc_tag_store u_dut (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
    .hit(hit), .hit_idx(hit_idx), .fill_idx(fill_idx), .repl_ptr(repl_ptr)
  );

  function automatic int unsigned blk(input logic [31:0] a);
    return a / 32;
  endfunction

  function automatic logic [31:0] mk(input int unsigned k, input int unsigned off);
    return (k * 4096 + 32'h155) * 32 + (off % 32);
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic cyc(input bit lv, input logic [31:0] la, input bit av,
                     input logic [31:0] aa, input string rq);
    bit mhit = 0, full = 1, dup = 0, adv;
    int unsigned midx = 0, mfree = 0, mfill;
    @(negedge clk);
    lkp_valid = lv; lkp_addr = la; alloc_valid = av; alloc_addr = aa;
    #1;
    for (int e = 63; e >= 0; e--) begin
      if (lv && mv[e] && mt[e] == blk(la)) begin mhit = 1; midx = e; end
      if (!mv[e]) begin full = 0; mfree = e; end
      if (av && mv[e] && mt[e] == blk(aa)) dup = 1;
    end
    mfill = full ? mptr : mfree;
    chk(rq, "hit", int'(hit), int'(mhit));
    chk(rq, "hit_idx", int'(hit_idx), int'(midx));
    chk(rq, "fill_idx", int'(fill_idx), int'(mfill));
    chk(rq, "repl_ptr", int'(repl_ptr), int'(mptr));
    adv = (mhit && midx == mptr) || (av && !dup && full);
    if (av && !dup) begin mv[mfill] = 1; mt[mfill] = blk(aa); end
    if (adv) mptr = (mptr + 1) % 64;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc(1, 32'h1234_5678, 0, 0, "R1");
    // R4 fill empty entries in order; R10 tags share low bits
    for (int i = 0; i < 64; i++) cyc(0, 0, 1, mk(i, 0), "R4");
    // R10 and R2: every block present, any byte offset
    for (int i = 0; i < 64; i++) cyc(1, mk(i, i * 7), 0, 0, "R10");
    cyc(1, mk(64, 3), 0, 0, "R3");          // miss
    cyc(1, mk(0, 31), 0, 0, "R6");          // hit on pointed entry 0
    cyc(1, mk(5, 1), 0, 0, "R6");           // hit elsewhere, pointer 1 holds
    cyc(0, 0, 0, 0, "R6");
    cyc(0, 0, 1, mk(70, 0), "R5");          // full: replaces entry 1
    cyc(1, mk(1, 0), 0, 0, "R5");           // evicted tag misses
    cyc(1, mk(70, 9), 0, 0, "R5");          // new tag hits at 1
    // R7 walk the pointer round to entry 0
    for (int n = 0; n < 64 && mptr != 0; n++) cyc(1, mk(0, 0) + 0, 0, 0, "R7") ;
    for (int n = 0; n < 64 && mptr != 0; n++) cyc(1, {mt[mptr][26:0], 5'd4}, 0, 0, "R7");
    cyc(0, 0, 0, 0, "R7");
    // R8 duplicate allocation ignored
    cyc(0, 0, 1, mk(7, 2), "R8");
    cyc(1, mk(7, 0), 0, 0, "R8");
    // R9 lookup hits pointed entry while the same entry is refilled
    cyc(1, {mt[mptr][26:0], 5'd0}, 1, mk(80, 0), "R9");
    cyc(1, mk(80, 5), 0, 0, "R9");
    cyc(1, mk(0, 0), 1, mk(81, 0), "R9");
    cyc(0, 0, 0, 0, "R9");
    // R9 random mix of lookups and fills
    for (int n = 0; n < 3000; n++) begin
      automatic bit lv = ($urandom % 4) != 0;
      automatic bit av = ($urandom % 3) == 0;
      cyc(lv, mk($urandom % 96, $urandom), av, mk($urandom % 96, $urandom), "R9");
    end
    cyc(0, 0, 0, 0, "R9");
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule